// File: doc/BRIEF.md
# Read-Priority Bus Request Queues

This block sits between a cache and the engine that drives the system bus. It keeps two separate queues: a two-slot queue for line reads and a three-slot queue for posted writes. A single request port runs towards the bus engine, and the block decides which queued request is offered there next. Reads come first, because a read stalls the core. A write leaves the core's view the moment the write queue takes it.

Each incoming read is compared with the addresses of every write already held in the write queue. When a read hits a buffered write, the block answers it locally with the data of the youngest matching write. That read never enters the read queue and never reaches the bus. A starvation guard keeps a long run of reads from holding back writes forever. A request offered on the bus port stays fixed until the bus engine takes it.

Top module: `brq_top`

## Requirements
- R1: After reset, `bus_valid` and `fwd_valid` are 0, and both `rd_ready` and `wr_ready` are 1.
- R2: The read queue holds 2 missing reads. With the bus stalled, `rd_ready` goes to 0 once two reads that missed are held.
- R3: The write queue holds 3 writes. With the bus stalled, `wr_ready` goes to 0 once three writes are held.
- R4: If the bus port is free to choose and the read queue is not empty, the request offered is a read (`bus_we`=0). This holds even while writes are waiting, unless R8 applies.
- R5: Writes go to the bus in the order they were accepted, with `bus_we`=1, their address on `bus_addr` and their data on `bus_wdata`. Writes are offered only when the read queue is empty, or under R8.
- R6: A read accepted in cycle N is compared with every write accepted before cycle N. It is not compared with a write accepted in the same cycle. On a hit on the full address, `fwd_valid` is 1 for exactly the cycle after acceptance, and `fwd_data` then holds the data of the youngest matching write. No bus read is issued for that read.
- R7: A write needs no response. While the write queue has room, `wr_ready` stays 1 even when the bus is stalled.
- R8: If writes are waiting and 8 reads in a row have been granted on the bus, the next request offered is the oldest write.
- R9: While `bus_valid`=1 and `bus_ready`=0, the offered request (`bus_we`, `bus_addr`, `bus_wdata`) keeps its value into the next cycle. A read that arrives meanwhile does not displace an offered write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid | input | 1 | Core read request |
| rd_ready | output | 1 | Read queue can accept a read |
| rd_addr | input | AW | Read address |
| wr_valid | input | 1 | Core write request |
| wr_ready | output | 1 | Write queue can accept a write |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| fwd_valid | output | 1 | Read answered from the write queue |
| fwd_data | output | DW | Forwarded write data |
| bus_valid | output | 1 | Request offered to the bus engine |
| bus_ready | input | 1 | Bus engine takes the request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Request address |
| bus_wdata | output | DW | Write data, 0 for reads |

## Verification
Inputs are driven just after a rising edge, so a request is taken at the next edge. Queue occupancy, `rd_ready`, `wr_ready` and the offered bus request all reflect that acceptance right after the edge, and the bench reads them at the following falling edge. A forwarded answer appears after the acceptance edge and lasts one cycle, so it is checked at that same falling edge. The bench records bus grants at the falling edge before the edge that completes them, and compares them in order with the expected sequence of reads and writes.

// File: rtl/brq_pkg.sv
package brq_pkg;
  localparam int ADDR_W_DEF = 16;
  localparam int DATA_W_DEF = 16;
  localparam int RDQ_DEPTH_DEF = 2;
  localparam int WRQ_DEPTH_DEF = 3;
  localparam int STARVE_DEF = 8;
endpackage

// File: rtl/brq_queue.sv
module brq_queue #(
  parameter int W = 8,
  parameter int DEPTH = 2,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    push,
  input  logic                    pop,
  input  logic [W-1:0]            din,
  output logic [DEPTH-1:0][W-1:0] ents,
  output logic [CW-1:0]           cnt,
  output logic                    full,
  output logic                    empty
);
  logic [DEPTH-1:0][W-1:0] mem_q, mem_d;
  logic [CW-1:0]           cnt_q, cnt_d;

  always_comb begin
    mem_d = mem_q;
    cnt_d = cnt_q;
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) mem_d[i] = mem_q[i+1];
      cnt_d = cnt_q - 1'b1;
    end
    if (push) begin
      for (int i = 0; i < DEPTH; i++)
        if (CW'(i) == cnt_d) mem_d[i] = din;
      cnt_d = cnt_d + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push || pop) mem_q <= mem_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (push || pop) cnt_q <= cnt_d;
  end

  assign ents  = mem_q;
  assign cnt   = cnt_q;
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> !full);
  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/brq_fwd.sv
module brq_fwd #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int DEPTH = 3,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic [AW-1:0]                 addr,
  input  logic [DEPTH-1:0][AW+DW-1:0]   ents,
  input  logic [CW-1:0]                 cnt,
  output logic                          hit,
  output logic [DW-1:0]                 data
);
  // entries are stored oldest first, so a later match overrides an earlier one
  always_comb begin
    hit  = 1'b0;
    data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((CW'(i) < cnt) && (ents[i][AW+DW-1:DW] == addr)) begin
        hit  = 1'b1;
        data = ents[i][DW-1:0];
      end
    end
  end
endmodule

// File: rtl/brq_arb.sv
module brq_arb #(
  parameter int STARVE_MAX = 8,
  localparam int SW = $clog2(STARVE_MAX + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_pend,
  input  logic wr_pend,
  input  logic bus_ready,
  output logic bus_valid,
  output logic sel_wr,
  output logic rd_pop,
  output logic wr_pop
);
  logic          hold_q, hold_d;
  logic          hold_wr_q, hold_wr_d;
  logic [SW-1:0] run_q, run_d;
  logic          grant;

  assign bus_valid = rd_pend || wr_pend;

  always_comb begin
    if (hold_q) sel_wr = hold_wr_q;
    else        sel_wr = wr_pend && (!rd_pend || (run_q == SW'(STARVE_MAX)));
    grant     = bus_valid && bus_ready;
    rd_pop    = grant && !sel_wr;
    wr_pop    = grant && sel_wr;
    hold_d    = bus_valid && !bus_ready;
    hold_wr_d = sel_wr;
    if (!wr_pend || wr_pop)                      run_d = '0;
    else if (rd_pop && run_q != SW'(STARVE_MAX)) run_d = run_q + 1'b1;
    else                                         run_d = run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= 1'b0;
      hold_wr_q <= 1'b0;
      run_q     <= '0;
    end else begin
      hold_q    <= hold_d;
      hold_wr_q <= hold_wr_d;
      run_q     <= run_d;
    end
  end

  // R9
  hold_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && sel_wr == $past(sel_wr)));
endmodule

// File: rtl/brq_top.sv
module brq_top
  import brq_pkg::*;
#(
  parameter int AW = ADDR_W_DEF,
  parameter int DW = DATA_W_DEF,
  parameter int RD_DEPTH = RDQ_DEPTH_DEF,
  parameter int WR_DEPTH = WRQ_DEPTH_DEF,
  parameter int STARVE_MAX = STARVE_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [AW-1:0] rd_addr,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          fwd_valid,
  output logic [DW-1:0] fwd_data,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata
);
  localparam int RCW = $clog2(RD_DEPTH + 1);
  localparam int WCW = $clog2(WR_DEPTH + 1);
  localparam int KW  = $clog2(STARVE_MAX + 2);

  logic [RD_DEPTH-1:0][AW-1:0]    rd_ents;
  logic [WR_DEPTH-1:0][AW+DW-1:0] wr_ents;
  logic [RCW-1:0] rd_cnt;
  logic [WCW-1:0] wr_cnt;
  logic rd_full, rd_empty, wr_full, wr_empty;
  logic rd_fire, wr_fire, hit, sel_wr, rd_pop, wr_pop;
  logic [DW-1:0] hit_data;
  logic fwd_valid_q;
  logic [DW-1:0] fwd_data_q;
  logic rd_unused;

  assign rd_ready = !rd_full;
  assign wr_ready = !wr_full;
  assign rd_fire  = rd_valid && rd_ready;
  assign wr_fire  = wr_valid && wr_ready;

  brq_queue #(.W(AW), .DEPTH(RD_DEPTH)) u_rdq (
    .clk(clk), .rst_n(rst_n), .push(rd_fire && !hit), .pop(rd_pop),
    .din(rd_addr), .ents(rd_ents), .cnt(rd_cnt), .full(rd_full), .empty(rd_empty));

  brq_queue #(.W(AW + DW), .DEPTH(WR_DEPTH)) u_wrq (
    .clk(clk), .rst_n(rst_n), .push(wr_fire), .pop(wr_pop),
    .din({wr_addr, wr_data}), .ents(wr_ents), .cnt(wr_cnt), .full(wr_full), .empty(wr_empty));

  brq_fwd #(.AW(AW), .DW(DW), .DEPTH(WR_DEPTH)) u_fwd (
    .addr(rd_addr), .ents(wr_ents), .cnt(wr_cnt), .hit(hit), .data(hit_data));

  brq_arb #(.STARVE_MAX(STARVE_MAX)) u_arb (
    .clk(clk), .rst_n(rst_n), .rd_pend(!rd_empty), .wr_pend(!wr_empty),
    .bus_ready(bus_ready), .bus_valid(bus_valid), .sel_wr(sel_wr),
    .rd_pop(rd_pop), .wr_pop(wr_pop));

  assign rd_unused = ^{rd_cnt, rd_ents};
  assign bus_we    = sel_wr;
  assign bus_addr  = sel_wr ? wr_ents[0][AW+DW-1:DW] : rd_ents[0];
  assign bus_wdata = sel_wr ? wr_ents[0][DW-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fwd_valid_q <= 1'b0;
    else        fwd_valid_q <= rd_fire && hit;
  end

  always_ff @(posedge clk) begin
    if (rd_fire && hit) fwd_data_q <= hit_data;
  end

  assign fwd_valid = fwd_valid_q;
  assign fwd_data  = fwd_data_q;

  // independent count of read grants in a row while a write waits
  logic [KW-1:0] streak_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) streak_q <= '0;
    else if (wr_empty || (bus_valid && bus_ready && bus_we)) streak_q <= '0;
    else if (bus_valid && bus_ready && !bus_we) streak_q <= streak_q + 1'b1;
  end

  // R8
  starve_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    streak_q <= KW'(STARVE_MAX));
  // R6
  fwd_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> $past(rd_valid && rd_ready));
  // R9
  bus_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_wdata)));
  // R3
  wr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_cnt != '0));
endmodule

// File: tb/brq_top_tb.sv
module brq_top_tb;
  localparam int AW = 16;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic rd_valid, wr_valid, bus_ready;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] wr_data;
  logic rd_ready, wr_ready, fwd_valid, bus_valid, bus_we;
  logic [DW-1:0] fwd_data, bus_wdata;
  logic [AW-1:0] bus_addr;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  brq_top u_dut (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .fwd_valid(fwd_valid), .fwd_data(fwd_data), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata));

  // {addr, expect hit, expect data}
  localparam logic [32:0] RD_VEC [4] = '{
    {16'h0010, 1'b1, 16'h00C3},
    {16'h0020, 1'b1, 16'h00B2},
    {16'h0050, 1'b0, 16'h0000},
    {16'h0070, 1'b0, 16'h0000}
  };
  // expected drain {we, addr, data}
  localparam logic [32:0] DRAIN_VEC [5] = '{
    {1'b1, 16'h0010, 16'h00A1},
    {1'b0, 16'h0050, 16'h0000},
    {1'b0, 16'h0070, 16'h0000},
    {1'b1, 16'h0020, 16'h00B2},
    {1'b1, 16'h0010, 16'h00C3}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rd_valid = 0; wr_valid = 0; bus_ready = 0;
    rd_addr = '0; wr_addr = '0; wr_data = '0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic push_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_valid = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1 wr_valid = 0;
  endtask

  task automatic push_rd(input logic [AW-1:0] a);
    rd_valid = 1; rd_addr = a;
    @(posedge clk); #1 rd_valid = 0;
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    check("R1 bus_valid", bus_valid, 0);
    check("R1 fwd_valid", fwd_valid, 0);
    check("R1 rd_ready", rd_ready, 1);
    check("R1 wr_ready", wr_ready, 1);
    @(posedge clk); #1;

    push_wr(16'h0010, 16'h00A1);
    push_wr(16'h0020, 16'h00B2);
    @(negedge clk);
    check("R7 wr_ready with bus stalled", wr_ready, 1);
    check("R9 write offered", {bus_valid, bus_we, bus_addr}, {2'b11, 16'h0010});
    @(posedge clk); #1;
    push_wr(16'h0010, 16'h00C3);
    @(negedge clk);
    check("R3 wr_ready at three", wr_ready, 0);
    @(posedge clk); #1;

    for (int i = 0; i < 4; i++) begin
      push_rd(RD_VEC[i][32:17]);
      @(negedge clk);
      check("R6 fwd_valid", fwd_valid, RD_VEC[i][16]);
      if (RD_VEC[i][16]) check("R6 fwd_data newest", fwd_data, RD_VEC[i][15:0]);
      @(posedge clk); #1;
    end
    @(negedge clk);
    check("R2 rd_ready at two", rd_ready, 0);
    check("R9 held write kept", {bus_we, bus_addr, bus_wdata}, {1'b1, 16'h0010, 16'h00A1});
    check("R6 no forward without read", fwd_valid, 0);
    @(posedge clk); #1;

    bus_ready = 1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R4 R5 grant order", {bus_valid, bus_we, bus_addr, bus_wdata}, {1'b1, DRAIN_VEC[i]});
      @(posedge clk); #1;
    end
    @(negedge clk);
    check("R5 drained", bus_valid, 0);

    // starvation guard
    do_reset();
    push_rd(16'h0100);
    push_wr(16'h0200, 16'h0055);
    @(negedge clk);
    check("R4 read before waiting write", {bus_valid, bus_we}, 2'b10);
    @(posedge clk); #1;
    bus_ready = 1; rd_valid = 1; rd_addr = 16'h0101;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (c < 8) check("R8 read granted", {bus_valid, bus_we}, 2'b10);
      else if (c == 8) check("R8 forced write", {bus_valid, bus_we, bus_addr}, {2'b11, 16'h0200});
      @(posedge clk); #1;
      rd_addr = rd_addr + 1'b1;
    end
    rd_valid = 0;
    repeat (4) @(posedge clk);
    #1;
    @(negedge clk);
    check("R5 all drained", bus_valid, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule